// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the register-programming front end of a single eight-input interrupt controller in the classic PC style. Software reaches it through a two-location byte port: an address select line, write and read strobes, and an 8-bit data bus. After reset the block expects a fixed run of initialization words. Once that run is complete, writes are decoded as operational commands: a command that ends an interrupt or changes priority, or a command that selects which status register is read back.

The block holds the initialization words, the interrupt mask, and the latched command fields. It exports the vector base, the cascade map, the mask and a mode word, along with a one-cycle strobe whenever an end-of-interrupt or priority command arrives. Priority resolution and in-service bookkeeping are done elsewhere. The pending-request vector and the in-service vector come in from that logic and are only read back here.

Top module: `pic_cmd_seq`

## Requirements
- R1: A write to address 0 with data bit 4 set is taken as the first initialization word in any state. It is stored, and the sequencer then waits for the second word, so `cfg_ready` is low.
- R2: A write to address 1 in the second-word state stores that word. The next state is the third-word state if bit 1 of the first word is 0, the fourth-word state if bit 1 is 1 and bit 0 is 1, and ready (`cfg_ready` high) otherwise.
- R3: A write to address 1 in the third-word state stores the cascade word. The next state is the fourth-word state if bit 0 of the first word is 1, and ready otherwise. A write to address 1 in the fourth-word state stores `mode_word` and always moves to ready.
- R4: `vec_base` shows the second initialization word with its low three bits forced to zero. `cascade_map` shows the third word as written.
- R5: A write to address 1 in the first-word state or in ready loads `irq_mask`. A write to address 1 during the second, third or fourth word leaves the mask unchanged.
- R6: In ready, a write to address 0 with bits 4:3 = 00 is a priority/EOI command. `cmd_stb` is high for exactly the one cycle after the write. `cmd_op` holds data bits 7:5 and `cmd_level` holds data bits 2:0, and both keep these values until the next such command.
- R7: In ready, a write to address 0 with bits 4:3 = 01 latches data bits 1:0 as the read select. A read of address 0 returns `isr_in` when the select is 11 and `irr_in` for any other select.
- R8: A read of address 1 returns `irq_mask`. Read data is registered: it appears the cycle after the read strobe and holds until the next read.
- R9: After reset, the sequencer is in the first-word state (`cfg_ready` low), the mask, vector base, cascade map and mode word are zero, no strobe is high, and the read select is 10, so that address 0 reads return `irr_in`.
- R10: Before ready, a write to address 0 with bit 4 clear is ignored: it gives no command strobe and changes no state. It raises `cmd_err` for the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a0 | input | 1 | Address select (0 or 1) |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| irr_in | input | 8 | Pending-request vector from the resolver |
| isr_in | input | 8 | In-service vector from the resolver |
| rdata | output | 8 | Registered read data |
| cfg_ready | output | 1 | Initialization finished |
| vec_base | output | 8 | Vector base, low three bits zero |
| cascade_map | output | 8 | Cascade word |
| mode_word | output | 8 | Fourth initialization word |
| irq_mask | output | 8 | Interrupt mask |
| cmd_stb | output | 1 | One-cycle strobe for a priority/EOI command |
| cmd_op | output | 3 | Command bits 7:5 of the last such command |
| cmd_level | output | 3 | Level bits 2:0 of the last such command |
| cmd_err | output | 1 | One-cycle flag for an ignored early write |

## Verification
Every result of a write or a read is due in the cycle that follows the strobe edge. This covers the state change, the stored words, the mask, the command strobe, the error flag and the read data. The bench drives each operation on a falling edge, updates its own expected model on the next rising edge, and compares every output on the falling edge after that. Strobe outputs are therefore checked both in the cycle they are due and in later cycles, where they must be low again. Read data is compared every cycle against the last value the model captured, which also checks that it holds between reads.

// File: rtl/pic_seq_pkg.sv
// Shared types for the interrupt controller programming sequencer.
// Assumes an 8-bit command bus; bit positions below are part of the protocol.
package pic_seq_pkg;

    // Programming sequencer states
    typedef enum logic [2:0] {
        ST_W1    = 3'd0,
        ST_W2    = 3'd1,
        ST_W3    = 3'd2,
        ST_W4    = 3'd3,
        ST_READY = 3'd4
    } seq_state_t;

    // One-hot classification of a bus write
    typedef struct packed {
        logic init1;
        logic init2;
        logic init3;
        logic init4;
        logic mask;
        logic prio;
        logic rsel;
        logic bad;
    } wr_kind_t;

    localparam int SEL_HI    = 4;  // data bit that marks the first init word
    localparam int SEL_LO    = 3;  // data bit that splits the two operational commands
    localparam int BIT_SNGL  = 1;  // single-unit flag in first init word
    localparam int BIT_IC4   = 0;  // fourth word expected
    localparam int VEC_LSB   = 3;  // vector base low bits forced to zero
    localparam int OP_LSB    = 5;  // command field start
    localparam int RSEL_W    = 2;  // read select width
    localparam logic [1:0] RSEL_ISR   = 2'b11;
    localparam logic [1:0] RSEL_RESET = 2'b10;

endpackage

// File: rtl/pic_wr_decode.sv
// Write classifier: turns one bus write plus the sequencer state into a
// one-hot kind. Purely combinational; assumes wr_en is a one-cycle strobe.
module pic_wr_decode
    import pic_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          wr_en,
    input  logic          a0,
    input  logic [DW-1:0] wdata,
    input  seq_state_t    state,
    output wr_kind_t      kind
);

    logic is_port0;
    logic is_port1;
    logic ready;

    assign is_port0 = wr_en && !a0;
    assign is_port1 = wr_en && a0;
    assign ready    = (state == ST_READY);

    // Classify the current write
    always_comb begin
        kind = '0;
        if (is_port0) begin
            if (wdata[SEL_HI])
                kind.init1 = 1'b1;
            else if (ready && !wdata[SEL_LO])
                kind.prio = 1'b1;
            else if (ready)
                kind.rsel = 1'b1;
            else
                kind.bad = 1'b1;
        end else if (is_port1) begin
            unique case (state)
                ST_W2:   kind.init2 = 1'b1;
                ST_W3:   kind.init3 = 1'b1;
                ST_W4:   kind.init4 = 1'b1;
                default: kind.mask  = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pic_init_fsm.sv
// Initialization sequencer: holds the four initialization words and steps
// through them. Assumes at most one write kind is active per cycle.
module pic_init_fsm
    import pic_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_kind_t      kind,
    input  logic [DW-1:0] wdata,
    output seq_state_t    state,
    output logic [DW-1:0] word1,
    output logic [DW-1:0] word2,
    output logic [DW-1:0] word3,
    output logic [DW-1:0] word4
);

    seq_state_t state_q, state_d;

    // Next-state selection from the stored first word
    always_comb begin
        state_d = state_q;
        if (kind.init1)
            state_d = ST_W2;
        else if (kind.init2) begin
            if (!word1[BIT_SNGL])
                state_d = ST_W3;
            else if (word1[BIT_IC4])
                state_d = ST_W4;
            else
                state_d = ST_READY;
        end else if (kind.init3)
            state_d = word1[BIT_IC4] ? ST_W4 : ST_READY;
        else if (kind.init4)
            state_d = ST_READY;
    end

    // State and word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_W1;
            word1   <= '0;
            word2   <= '0;
            word3   <= '0;
            word4   <= '0;
        end else begin
            state_q <= state_d;
            if (kind.init1) word1 <= wdata;
            if (kind.init2) word2 <= wdata;
            if (kind.init3) word3 <= wdata;
            if (kind.init4) word4 <= wdata;
        end
    end

    assign state = state_q;

    AST_INIT1_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        kind.init1 |=> (state_q == ST_W2)); // R1

    AST_SNGL_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind.init2 && !word1[BIT_SNGL]) |=> (state_q == ST_W3)); // R2

    AST_W4_NEEDS_IC4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_W4) |-> word1[BIT_IC4]); // R3

endmodule

// File: rtl/pic_op_regs.sv
// Operational registers: interrupt mask, read select and the latched
// priority/EOI command, plus the one-cycle command and error strobes.
module pic_op_regs
    import pic_seq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_kind_t         kind,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    mask,
    output logic [RSEL_W-1:0] rsel,
    output logic             cmd_stb,
    output logic [DW-OP_LSB-1:0] cmd_op,
    output logic [LVL_W-1:0] cmd_level,
    output logic             cmd_err
);

    // Mask and read-select latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            rsel <= RSEL_RESET;
        end else begin
            if (kind.mask) mask <= wdata;
            if (kind.rsel) rsel <= wdata[RSEL_W-1:0];
        end
    end

    // Command fields and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_op    <= '0;
            cmd_level <= '0;
            cmd_stb   <= 1'b0;
            cmd_err   <= 1'b0;
        end else begin
            cmd_stb <= kind.prio;
            cmd_err <= kind.bad;
            if (kind.prio) begin
                cmd_op    <= wdata[DW-1:OP_LSB];
                cmd_level <= wdata[LVL_W-1:0];
            end
        end
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kind.mask |=> (mask == $past(wdata))); // R5

    AST_MASK_HOLD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (kind.init2 || kind.init3 || kind.init4) |=> $stable(mask)); // R5

endmodule

// File: rtl/pic_readback.sv
// Read-back port: registers the selected status byte one cycle after the
// read strobe and holds it until the next read.
module pic_readback
    import pic_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              a0,
    input  logic [RSEL_W-1:0] rsel,
    input  logic [DW-1:0]     irr,
    input  logic [DW-1:0]     isr,
    input  logic [DW-1:0]     mask,
    output logic [DW-1:0]     rdata
);

    logic [DW-1:0] pick;

    // Source selection
    always_comb begin
        if (a0)
            pick = mask;
        else if (rsel == RSEL_ISR)
            pick = isr;
        else
            pick = irr;
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= pick;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R8

    AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && a0) |=> (rdata == $past(mask))); // R8

endmodule

// File: rtl/pic_cmd_seq.sv
// Interrupt controller programming sequencer top. Decodes byte writes on a
// two-location port into initialization words and operational commands and
// exports the resulting configuration. Assumes writes and reads are single-
// cycle strobes; priority resolution lives outside this block.
module pic_cmd_seq
    import pic_seq_pkg::*;
#(
    parameter int DW = 8,
    localparam int LVL_W = $clog2(DW),
    localparam int OP_W  = DW - OP_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a0,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    irr_in,
    input  logic [DW-1:0]    isr_in,
    output logic [DW-1:0]    rdata,
    output logic             cfg_ready,
    output logic [DW-1:0]    vec_base,
    output logic [DW-1:0]    cascade_map,
    output logic [DW-1:0]    mode_word,
    output logic [DW-1:0]    irq_mask,
    output logic             cmd_stb,
    output logic [OP_W-1:0]  cmd_op,
    output logic [LVL_W-1:0] cmd_level,
    output logic             cmd_err
);

    seq_state_t        state;
    wr_kind_t          kind;
    logic [DW-1:0]     word1, word2;
    logic [RSEL_W-1:0] rsel;

    pic_wr_decode #(.DW(DW)) u_dec (
        .wr_en (wr_en),
        .a0    (a0),
        .wdata (wdata),
        .state (state),
        .kind  (kind)
    );

    pic_init_fsm #(.DW(DW)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .wdata (wdata),
        .state (state),
        .word1 (word1),
        .word2 (word2),
        .word3 (cascade_map),
        .word4 (mode_word)
    );

    pic_op_regs #(.DW(DW), .LVL_W(LVL_W)) u_ops (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .wdata     (wdata),
        .mask      (irq_mask),
        .rsel      (rsel),
        .cmd_stb   (cmd_stb),
        .cmd_op    (cmd_op),
        .cmd_level (cmd_level),
        .cmd_err   (cmd_err)
    );

    pic_readback #(.DW(DW)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .a0    (a0),
        .rsel  (rsel),
        .irr   (irr_in),
        .isr   (isr_in),
        .mask  (irq_mask),
        .rdata (rdata)
    );

    logic unused_word1;
    assign unused_word1 = ^word1[DW-1:2];

    assign cfg_ready = (state == ST_READY);

    // Vector base: low bits dropped, parameter picks the split
    generate
        if (VEC_LSB > 0) begin : g_vbase
            assign vec_base = {word2[DW-1:VEC_LSB], {VEC_LSB{1'b0}}};
        end else begin : g_vbase_full
            assign vec_base = word2;
        end
    endgenerate

    AST_CMD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $past(wr_en && !a0 && cfg_ready
                          && (wdata[SEL_HI:SEL_LO] == 2'b00))); // R6

    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(wr_en && !a0 && !cfg_ready && !wdata[SEL_HI])); // R10

    AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_err && cmd_stb)); // R10

    AST_VEC_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vec_base[VEC_LSB-1:0] == '0); // R4

endmodule

// File: tb/sim_pic_cmd_seq.sv
module sim_pic_cmd_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       a0, wr_en, rd_en;
    logic [7:0] wdata, irr_in, isr_in;
    logic [7:0] rdata, vec_base, cascade_map, mode_word, irq_mask;
    logic       cfg_ready, cmd_stb, cmd_err;
    logic [2:0] cmd_op, cmd_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // expected model
    int         m_st;
    logic [7:0] m_w1, m_w2, m_w3, m_w4, m_mask, m_rdata;
    logic [1:0] m_sel;
    logic [2:0] m_op, m_lvl;
    logic       m_stb, m_err;

    always #2.5 clk = ~clk;

    pic_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .a0(a0), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .irr_in(irr_in), .isr_in(isr_in), .rdata(rdata),
        .cfg_ready(cfg_ready), .vec_base(vec_base), .cascade_map(cascade_map),
        .mode_word(mode_word), .irq_mask(irq_mask), .cmd_stb(cmd_stb),
        .cmd_op(cmd_op), .cmd_level(cmd_level), .cmd_err(cmd_err)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_w1 = 0; m_w2 = 0; m_w3 = 0; m_w4 = 0; m_mask = 0;
        m_rdata = 0; m_sel = 2'b10; m_op = 0; m_lvl = 0; m_stb = 0; m_err = 0;
    endtask

    // expected effect of one operation, applied at the rising edge
    task automatic model_step(input logic wr, input logic rd, input logic ad, input logic [7:0] d);
        m_stb = 0; m_err = 0;
        if (rd) m_rdata = ad ? m_mask : ((m_sel == 2'b11) ? isr_in : irr_in);
        if (wr && !ad) begin
            if (d[4]) begin m_w1 = d; m_st = 1; end
            else if (m_st == 4) begin
                if (!d[3]) begin m_stb = 1; m_op = d[7:5]; m_lvl = d[2:0]; end
                else m_sel = d[1:0];
            end else m_err = 1;
        end else if (wr) begin
            case (m_st)
                1: begin m_w2 = d; m_st = !m_w1[1] ? 2 : (m_w1[0] ? 3 : 4); end
                2: begin m_w3 = d; m_st = m_w1[0] ? 3 : 4; end
                3: begin m_w4 = d; m_st = 4; end
                default: m_mask = d;
            endcase
        end
    endtask

    task automatic check_all(input string ctx);
        chk({ctx, " R1,R2,R3 ready"}, {7'd0, cfg_ready}, {7'd0, m_st == 4});
        chk({ctx, " R4 vec_base"}, vec_base, {m_w2[7:3], 3'b000});
        chk({ctx, " R4 cascade"}, cascade_map, m_w3);
        chk({ctx, " R3 mode_word"}, mode_word, m_w4);
        chk({ctx, " R5 mask"}, irq_mask, m_mask);
        chk({ctx, " R6 cmd_stb"}, {7'd0, cmd_stb}, {7'd0, m_stb});
        chk({ctx, " R6 cmd fields"}, {2'b00, cmd_op, cmd_level}, {2'b00, m_op, m_lvl});
        chk({ctx, " R10 cmd_err"}, {7'd0, cmd_err}, {7'd0, m_err});
        chk({ctx, " R7,R8 rdata"}, rdata, m_rdata);
    endtask

    // drive at falling edge, model at rising edge, compare at next falling edge
    task automatic op(input logic wr, input logic rd, input logic ad, input logic [7:0] d, input string ctx);
        wr_en = wr; rd_en = rd; a0 = ad; wdata = d;
        @(posedge clk);
        model_step(wr, rd, ad, d);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check_all(ctx);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        rst_n = 0; a0 = 0; wr_en = 0; rd_en = 0; wdata = 0;
        irr_in = 8'h5a; isr_in = 8'hc3;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R9 reset");
        op(0, 1, 0, 8'h00, "R9 reset read selects irr");
        // single unit, no fourth word: ready right after second word
        op(1, 0, 0, 8'h12, "R1 init1 sngl");
        op(1, 0, 1, 8'h2f, "R2 init2 to ready");
        // error before ready: restart then bit4 clear
        op(1, 0, 0, 8'h11, "R1 restart from ready");
        op(1, 0, 0, 8'h20, "R10 early write ignored");
        op(1, 0, 1, 8'h47, "R2 init2 cascade");
        op(1, 0, 1, 8'h04, "R3 cascade word");
        op(1, 0, 1, 8'h01, "R3 mode word");
        op(1, 0, 1, 8'ha5, "R5 mask load");
        op(1, 0, 0, 8'h63, "R6 prio cmd");
        op(0, 0, 0, 8'h00, "R6 strobe drops");
        op(1, 0, 0, 8'h0b, "R7 select isr");
        op(0, 1, 0, 8'h00, "R7 read isr");
        op(1, 0, 0, 8'h09, "R7 select 01 reads irr");
        op(0, 1, 0, 8'h00, "R7 read irr");
        op(0, 1, 1, 8'h00, "R8 read mask");
        // mask untouched during init sequence (sngl=0, ic4=0)
        op(1, 0, 0, 8'h10, "R1 init1");
        op(1, 0, 1, 8'h88, "R5 init2 not mask");
        op(1, 0, 1, 8'hf0, "R5 init3 not mask");
        op(0, 1, 1, 8'h00, "R8 mask after init");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [7:0] d;
            r = $urandom % 10;
            d = 8'($urandom);
            irr_in = 8'($urandom);
            isr_in = 8'($urandom);
            if (r == 0)      d[4] = 1'b1;
            else if (r < 4)  d[4] = 1'b0;
            if (r < 4)       op(1, 0, 0, d, "rand port0");
            else if (r < 7)  op(1, 0, 1, d, "rand port1");
            else if (r < 9)  op(0, 1, r[0], d, "rand read");
            else             op(0, 0, 0, d, "rand idle");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule